// File: doc/BRIEF.md
# SDRAM Mode Register Write Controller

This block watches the command and address pins of a mobile DDR SDRAM device model. When chip select, row strobe, column strobe and write enable are all low at a rising clock edge, it treats the edge as a mode register write. It checks the captured address and bank bits against the small set of legal encodings, and then either loads a mode register or flags the command as illegal. The mode register holds the burst length, the burst ordering and the CAS latency.

A write that is accepted opens a completion window. While the window is open the block ignores any further command and raises `busy`. The decoded fields come from registers, so the device model can read them directly as its burst and latency configuration. The register can be rewritten as often as needed after reset.

Top module: `sdram_mrs_ctrl`

## Requirements
- R1: A mode register write is recognised only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at the same rising edge. The new fields appear on the outputs from the next cycle. Any other command pattern changes nothing and raises no flag.
- R2: When `cke` is low at the sampling edge, the command is ignored. The fields stay unchanged and `illegal` stays low.
- R3: Field encoding. `addr[2:0]` values 001, 010, 011 and 100 give `burst_beats` of 2, 4, 8 and 16. `addr[3]` gives `burst_ilv` (0 means sequential, 1 means interleaved). `addr[6:4]` = 011 gives `cas_lat` = 3.
- R4: An accepted write holds `busy` high for WR_CYCLES-1 cycles after the edge (one cycle by default). A command at an edge inside that window is ignored: there is no update and no flag. A command WR_CYCLES edges after the accepted one is accepted again.
- R5: If `banks_idle` is low, the command is rejected. `illegal` goes high for exactly the cycle after the edge, and the fields are left unchanged.
- R6: A nonzero `ba` rejects the command, with the flag set and the fields unchanged.
- R7: The burst length codes 000, 101, 110 and 111 are reserved. They reject the command, with the flag set and the fields unchanged.
- R8: Any `addr[6:4]` other than 011 rejects the command, with the flag set and the fields unchanged.
- R9: Any nonzero bit in `addr[13:7]` rejects the command, with the flag set and the fields unchanged.
- R10: After reset, the outputs are: 2 beats, sequential, CAS latency 3, `busy` low and `illegal` low.
- R11: The register accepts any number of rewrites, each following the same rules. A rejected command never opens the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; must be high for a command to take effect |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 14 | Address bus captured with the command |
| ba | input | 2 | Bank address, must be zero |
| banks_idle | input | 1 | High when every bank is idle |
| burst_beats | output | 5 | Burst length in beats (2, 4, 8 or 16) |
| burst_ilv | output | 1 | 1 for interleaved ordering, 0 for sequential |
| cas_lat | output | 3 | CAS latency in cycles |
| busy | output | 1 | Completion window open |
| illegal | output | 1 | One-cycle pulse for a rejected write |

## Verification
The bench sweeps all 128 values of the low seven address bits. This catches a decoder that accepts a reserved burst code, accepts a latency other than 3, or maps a length code to the wrong beat count; any of these would load a bad field or miss the flag. Each reserved high address bit and each nonzero bank value is driven on its own, because a decoder that checks only part of that range would silently accept the command. The bench issues a second write on the edge right after an accepted one, and again one edge later. A window that is too short would take the second write, and a window that is too long would drop the third. Writes with `cke` low, with banks active, and with a non-write command pattern confirm that the wrong gating leaves no trace on the fields or the flag.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int BEATS_W = 5;
  localparam int CL_W    = 3;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic [BEATS_W-1:0] beats;
    burst_order_e       order;
    logic [CL_W-1:0]    cl;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '{beats: 5'd2, order: ORDER_SEQ, cl: 3'd3};
endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
  import mrs_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int BA_W       = 2,
  parameter int CL_ALLOWED = 3,
  parameter int BL_MIN     = 1,
  parameter int BL_MAX     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  input  logic              banks_idle,
  output logic              ok,
  output mode_t             mode
);
  localparam int RSV_LO = 7;

  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic       bl_ok, cl_ok, rsv_ok, ba_ok;

  always_comb begin
    bl_code = addr[2:0];
    cl_code = addr[6:4];
    bl_ok   = (int'(bl_code) >= BL_MIN) && (int'(bl_code) <= BL_MAX);
    cl_ok   = (int'(cl_code) == CL_ALLOWED);
    rsv_ok  = (addr[ADDR_W-1:RSV_LO] == '0);
    ba_ok   = (ba == '0);
    ok      = bl_ok && cl_ok && rsv_ok && ba_ok && banks_idle;
    mode.beats = BEATS_W'(1) << bl_code;
    mode.order = burst_order_e'(addr[3]);
    mode.cl    = cl_code;
  end
endmodule

// File: rtl/mrs_window.sv
module mrs_window #(
  parameter int WR_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  generate
    if (WR_CYCLES <= 1) begin : g_none
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int CW = $clog2(WR_CYCLES);
      localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start)         cnt <= LOAD;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/sdram_mrs_ctrl.sv
module sdram_mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int BA_W      = 2,
  parameter int WR_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cke,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BA_W-1:0]    ba,
  input  logic               banks_idle,
  output logic [BEATS_W-1:0] burst_beats,
  output logic               burst_ilv,
  output logic [CL_W-1:0]    cas_lat,
  output logic               busy,
  output logic               illegal
);
  logic  cmd_hit, dec_ok, accept;
  mode_t dec_mode, mode_q;
  logic  illegal_q;

  assign cmd_hit = cke && !cs_n && !ras_n && !cas_n && !we_n && !busy;
  assign accept  = cmd_hit && dec_ok;

  mrs_decode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dec (
    .addr       (addr),
    .ba         (ba),
    .banks_idle (banks_idle),
    .ok         (dec_ok),
    .mode       (dec_mode)
  );

  mrs_window #(.WR_CYCLES(WR_CYCLES)) u_win (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_DEFAULT;
      illegal_q <= 1'b0;
    end else begin
      if (accept) mode_q <= dec_mode;
      illegal_q <= cmd_hit && !dec_ok;
    end
  end

  assign burst_beats = mode_q.beats;
  assign burst_ilv   = mode_q.order;
  assign cas_lat     = mode_q.cl;
  assign illegal     = illegal_q;
endmodule

// File: rtl/mrs_chk.sv
module mrs_chk #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              banks_idle,
  input logic [4:0]        burst_beats,
  input logic              burst_ilv,
  input logic [2:0]        cas_lat,
  input logic              busy,
  input logic              illegal
);
  logic       seen;
  logic [8:0] fields;
  assign seen   = cke && !cs_n && !ras_n && !cas_n && !we_n && !busy;
  assign fields = {burst_beats, burst_ilv, cas_lat};

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(fields) && !illegal)); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(fields) && !illegal)); // R4
  AST_NOT_IDLE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (seen && !banks_idle) |=> (illegal && $stable(fields))); // R5
  AST_BANK_REJECT: assert property (@(posedge clk) disable iff (rst)
    (seen && ba != '0) |=> (illegal && $stable(fields))); // R6
  AST_RSV_REJECT: assert property (@(posedge clk) disable iff (rst)
    (seen && addr[ADDR_W-1:7] != '0) |=> (illegal && $stable(fields))); // R9
  AST_LEGAL_FIELDS: assert property (@(posedge clk) disable iff (rst)
    ($countones(burst_beats) == 1 && burst_beats != 5'd1 && cas_lat == 3'd3)); // R3
  AST_REJECT_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy); // R11
endmodule

bind sdram_mrs_ctrl mrs_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .banks_idle(banks_idle),
  .burst_beats(burst_beats), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
  .busy(busy), .illegal(illegal)
);

// File: tb/sim_sdram_mrs_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_mrs_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [13:0] addr = '0;
  logic [1:0]  ba = '0;
  logic        banks_idle = 1'b1;
  logic [4:0]  burst_beats;
  logic        burst_ilv;
  logic [2:0]  cas_lat;
  logic        busy, illegal;

  int total = 0;
  int bad   = 0;
  int e_beats = 2, e_ilv = 0, e_cl = 3;

  always #2.5 clk = ~clk;

  sdram_mrs_ctrl u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .banks_idle(banks_idle),
    .burst_beats(burst_beats), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
    .busy(busy), .illegal(illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_busy, input int e_ill);
    chk({tag, " beats"},   int'(burst_beats), e_beats);
    chk({tag, " order"},   int'(burst_ilv),   e_ilv);
    chk({tag, " latency"}, int'(cas_lat),     e_cl);
    chk({tag, " busy"},    int'(busy),        e_busy);
    chk({tag, " illegal"}, int'(illegal),     e_ill);
  endtask

  // cmd bits: {cs_n, ras_n, cas_n, we_n}; drive at a negedge, return at the next
  task automatic drive(input logic c, input logic [3:0] cmd, input logic [13:0] a,
                       input logic [1:0] b, input logic idle);
    cke = c; {cs_n, ras_n, cas_n, we_n} = cmd; addr = a; ba = b; banks_idle = idle;
    @(negedge clk);
    cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = 4'b1111; addr = '0; ba = '0; banks_idle = 1'b1;
  endtask

  function automatic bit lgl(input logic [13:0] a, input logic [1:0] b, input logic idle);
    return idle && b == 2'd0 && a[13:7] == 7'd0 && a[6:4] == 3'd3 &&
           a[2:0] >= 3'd1 && a[2:0] <= 3'd4;
  endfunction

  task automatic model(input logic [13:0] a);
    e_beats = 1 << a[2:0];
    e_ilv   = int'(a[3]);
    e_cl    = int'(a[6:4]);
  endtask

  task automatic nop_gap();
    drive(1'b1, 4'b1111, '0, '0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_all("R10 reset", 0, 0);

    // R1: near-miss command patterns do nothing
    drive(1'b1, 4'b0001, 14'h3A, 2'd0, 1'b1);
    chk_all("R1 we high", 0, 0);
    drive(1'b1, 4'b1000, 14'h3A, 2'd0, 1'b1);
    chk_all("R1 cs high", 0, 0);
    drive(1'b1, 4'b0100, 14'h3A, 2'd0, 1'b1);
    chk_all("R1 ras high", 0, 0);

    // R3 R7 R8: every value of the low seven address bits
    for (int a = 0; a < 128; a++) begin
      bit ok;
      ok = lgl(14'(a), 2'd0, 1'b1);
      drive(1'b1, 4'b0000, 14'(a), 2'd0, 1'b1);
      if (ok) model(14'(a));
      chk_all(ok ? "R3 sweep" : (a[6:4] != 3 ? "R8 sweep" : "R7 sweep"),
              int'(ok), int'(!ok));
      nop_gap();
      chk_all("R11 sweep gap", 0, 0);
    end

    // R9: each reserved high bit alone
    for (int b = 7; b < 14; b++) begin
      drive(1'b1, 4'b0000, 14'h32 | (14'd1 << b), 2'd0, 1'b1);
      chk_all("R9 high bit", 0, 1);
      nop_gap();
    end

    // R6: nonzero bank bits
    for (int b = 1; b < 4; b++) begin
      drive(1'b1, 4'b0000, 14'h32, 2'(b), 1'b1);
      chk_all("R6 bank", 0, 1);
      nop_gap();
      chk_all("R6 pulse end", 0, 0);
    end

    // R5: banks not idle
    drive(1'b1, 4'b0000, 14'h32, 2'd0, 1'b0);
    chk_all("R5 not idle", 0, 1);
    nop_gap();
    chk_all("R5 pulse end", 0, 0);

    // R2: clock enable low, both legal and illegal contents
    drive(1'b0, 4'b0000, 14'h32, 2'd0, 1'b1);
    chk_all("R2 cke low legal", 0, 0);
    drive(1'b0, 4'b0000, 14'h00, 2'd1, 1'b0);
    chk_all("R2 cke low bad", 0, 0);

    // R4: write, blocked write, then accepted write
    drive(1'b1, 4'b0000, 14'h39, 2'd0, 1'b1);
    model(14'h39);
    chk_all("R4 first", 1, 0);
    drive(1'b1, 4'b0000, 14'h33, 2'd0, 1'b1);
    chk_all("R4 blocked", 0, 0);
    drive(1'b1, 4'b0000, 14'h33, 2'd0, 1'b1);
    model(14'h33);
    chk_all("R4 reopen", 1, 0);
    drive(1'b1, 4'b0000, 14'h00, 2'd2, 1'b0);
    chk_all("R4 bad in window", 0, 0);

    // R11: back-to-back rewrites at the minimum spacing
    for (int k = 1; k <= 4; k++) begin
      logic [13:0] a;
      a = 14'h30 | 14'(k) | ((k % 2 == 0) ? 14'h8 : 14'h0);
      drive(1'b1, 4'b0000, a, 2'd0, 1'b1);
      model(a);
      chk_all("R11 rewrite", 1, 0);
      nop_gap();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule